// File: doc/BRIEF.md
# DRAM Command Subsequence Engine

This block drives the command side of one DRAM channel during training and memory test. Software fills up to four subsequence slots through a word-addressed register port. Each slot names a command code, how many times to issue it, the spacing between issues, and how long to pause once the slot is finished. A slot also carries a data-direction tag, a start column/row address, a bank, a rank and rules for stepping the address and bank.

Writing the launch word starts the engine. The launch word gives the number of passes over the list, the index of the last slot to use, and a flag that runs the same timing with no commands driven. On each clock the output bus carries at most one command, as a one-cycle valid pulse with its code, address, bank, rank and direction. The bus reads all zeros between commands. Completion appears as one of two bits in the status word, which software polls.

Top module: `dram_cmd_seq`

## Requirements
- R1: Register word `4*s+k` (s = slot 0..3) holds slot s, and every stored word reads back unchanged.
  - k=0: command code in bits [3:0].
  - k=1: repeat count in [8:0], direction in [13:12] (0 none, 1 read, 2 write), gap in [20:16], post-wait in [31:24].
  - k=2: address in [15:0], bank in [18:16], rank in [21:20].
  - k=3: add-8 enable in bit 0, bank-step enable in bit 1, wrap position in [8:4].
- R2: A write to word 16 while idle launches a run. The word carries pass count in bits [7:0], last slot index in [19:18] and silent-timing flag in bit 22. The first command is valid in the second cycle after the write edge.
- R3: A slot issues its command `count` times; a count of 0 acts as 1 and counts up to 511 are supported. Consecutive issues in a slot lie exactly `gap` cycles apart; a gap of 0 acts as 1.
- R4: The first issue of the next slot comes exactly `post`+1 cycles after the last issue of the current slot.
- R5: Each command pulse lasts one cycle and carries the slot's code, direction and rank. The bus carries the current address and bank. When valid is low, code, address, bank, rank and direction are all zero.
- R6: With add-8 enabled, the address rises by 8 after each issue. If that addition changes any bit at or above the wrap position, the address returns to the slot's start value. A wrap position of 16 or more never reloads, and the address wraps modulo 2^16.
- R7: With bank-step enabled, the bank rises by 1 after each issue, modulo 8.
- R8: Address and bank restart from the slot's programmed values each time a slot begins. Slots 0..last are run in order, once per pass, for the programmed number of passes.
- R9: Word 17 reads as the status word: bit 0 busy, bit 4 done, bit 6 done-silent. After a normal run, bit 4 sets `post`+1 cycles after the final issue, at the moment busy clears. Busy and done are never set together.
- R10: With the silent-timing flag set, no command pulse is driven. Bit 6, not bit 4, sets at the same cycle as it would for a normal run.
- R11: A pass count of 0 drives no command and sets the done bit (bit 6 if silent) in the cycle after the write.
- R12: While busy, writes to word 16 and to slot words are ignored. The run continues unchanged and the slot words keep their old values.
- R13: Launching a run clears both done bits in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 4 | Command code |
| cmd_addr | output | 16 | Command address |
| cmd_bank | output | 3 | Command bank |
| cmd_rank | output | 2 | Target rank |
| cmd_dir | output | 2 | Data-direction tag |

## Verification
The bound checker watches the bus and the status bits on every cycle:
- the bus is zero whenever valid is low;
- no pulse appears outside a run or in silent timing;
- busy excludes done, and the two done bits are never both set;
- an idle launch always raises busy;
- a launch during a run leaves the mode untouched.

Exact spacing needs the bench's scenarios:
- gap and post-wait cycle counts;
- the zero-count and zero-gap substitutions;
- the address wrap rule and bank stepping;
- reload of start values on each pass and the completion cycle.

The bench computes these arithmetically over a sweep of slot counts, gaps and waits.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int NSLOT          = 4;
    localparam int SLOT_W         = $clog2(NSLOT);
    localparam int WORDS_PER_SLOT = 4;
    localparam int NWORDS         = NSLOT * WORDS_PER_SLOT;
    localparam int REG_AW         = 5;
    localparam int LOOP_W         = 8;
    localparam int CNT_W          = 9;
    localparam int GAP_W          = 5;
    localparam int WAIT_W         = 8;
    localparam int TMR_W          = (GAP_W > WAIT_W) ? GAP_W : WAIT_W;
    localparam int ADDR_W         = 16;
    localparam int BANK_W         = 3;
    localparam int RANK_W         = 2;
    localparam int CODE_W         = 4;
    localparam int DIR_W          = 2;
    localparam int WRAP_W         = 5;

    // slot word 1
    localparam int CNT_LSB  = 0;
    localparam int DIR_LSB  = 12;
    localparam int GAP_LSB  = 16;
    localparam int WAIT_LSB = 24;
    // slot word 2
    localparam int ADR_LSB  = 0;
    localparam int BANK_LSB = 16;
    localparam int RANK_LSB = 20;
    // slot word 3
    localparam int INC8_BIT = 0;
    localparam int INCB_BIT = 1;
    localparam int WRAP_LSB = 4;
    // launch word (positions fixed by software convention)
    localparam int LOOP_LSB  = 0;
    localparam int LAST_LSB  = 18;
    localparam int TIMER_BIT = 22;
    // status word
    localparam int BUSY_BIT  = 0;
    localparam int DONE_BIT  = 4;
    localparam int TDONE_BIT = 6;

    localparam logic [REG_AW-1:0] REG_START  = REG_AW'(16);
    localparam logic [REG_AW-1:0] REG_STATUS = REG_AW'(17);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
        logic [GAP_W-1:0]  gap;
        logic [WAIT_W-1:0] post;
        logic [DIR_W-1:0]  dir;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic              inc8;
        logic              incbank;
        logic [WRAP_W-1:0] wrap;
    } desc_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] last;
        logic [LOOP_W-1:0] loops;
        logic [CNT_W-1:0]  left;
        logic [TMR_W-1:0]  tmr;
        logic [ADDR_W-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              tmode;
        logic              done_n;
        logic              done_t;
        logic              vld;
        logic [CODE_W-1:0] code;
        logic [DIR_W-1:0]  dir;
        logic [ADDR_W-1:0] oaddr;
        logic [BANK_W-1:0] obank;
        logic [RANK_W-1:0] orank;
    } eng_t;
endpackage

// File: rtl/dcs_addr_step.sv
module dcs_addr_step #(
    parameter int AW = 16,
    parameter int WW = 5,
    parameter int STEP = 8
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic          inc,
    input  logic [WW-1:0] wrap,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] sum;
    logic [AW-1:0] hit;

    assign sum = cur + AW'(STEP);

    // a bit at or above the wrap position that the addition changed
    for (genvar i = 0; i < AW; i++) begin : g_hit
        assign hit[i] = (int'(wrap) <= i) && (sum[i] ^ cur[i]);
    end

    assign nxt = !inc ? cur : ((|hit) ? base : sum);
endmodule

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              lock,
    input  logic [31:0]       status_word,
    output logic [31:0]       rd_data,
    output desc_t             desc [NSLOT]
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam logic [REG_AW-1:0] WORD_LIM = REG_AW'(NWORDS);

    logic [31:0] word_q [NWORDS];
    logic [31:0] word_d [NWORDS];
    logic [31:0] start_q, start_d;

    always_comb begin
        word_d  = word_q;
        start_d = start_q;
        if (wr_en && !lock) begin
            if (addr < WORD_LIM) begin
                word_d[addr[IDX_W-1:0]] = wr_data;
            end else if (addr == REG_START) begin
                start_d = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) word_q[i] <= '0;
            start_q <= '0;
        end else begin
            for (int i = 0; i < NWORDS; i++) word_q[i] <= word_d[i];
            start_q <= start_d;
        end
    end

    always_comb begin
        if (addr < WORD_LIM)          rd_data = word_q[addr[IDX_W-1:0]];
        else if (addr == REG_START)   rd_data = start_q;
        else if (addr == REG_STATUS)  rd_data = status_word;
        else                          rd_data = '0;
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            desc[s].code    = word_q[s*WORDS_PER_SLOT+0][CODE_W-1:0];
            desc[s].count   = word_q[s*WORDS_PER_SLOT+1][CNT_LSB  +: CNT_W];
            desc[s].dir     = word_q[s*WORDS_PER_SLOT+1][DIR_LSB  +: DIR_W];
            desc[s].gap     = word_q[s*WORDS_PER_SLOT+1][GAP_LSB  +: GAP_W];
            desc[s].post    = word_q[s*WORDS_PER_SLOT+1][WAIT_LSB +: WAIT_W];
            desc[s].addr    = word_q[s*WORDS_PER_SLOT+2][ADR_LSB  +: ADDR_W];
            desc[s].bank    = word_q[s*WORDS_PER_SLOT+2][BANK_LSB +: BANK_W];
            desc[s].rank    = word_q[s*WORDS_PER_SLOT+2][RANK_LSB +: RANK_W];
            desc[s].inc8    = word_q[s*WORDS_PER_SLOT+3][INC8_BIT];
            desc[s].incbank = word_q[s*WORDS_PER_SLOT+3][INCB_BIT];
            desc[s].wrap    = word_q[s*WORDS_PER_SLOT+3][WRAP_LSB +: WRAP_W];
        end
    end
endmodule

// File: rtl/dcs_engine.sv
module dcs_engine
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LOOP_W-1:0] go_loops,
    input  logic [SLOT_W-1:0] go_last,
    input  logic              go_timer,
    input  desc_t             desc [NSLOT],
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [DIR_W-1:0]  cmd_dir,
    output logic              busy,
    output logic              done_n,
    output logic              done_t,
    output logic              tmode
);
    eng_t  q, d;
    desc_t cur, nxt;
    logic [ADDR_W-1:0] step_addr;

    function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
        return (c == '0) ? CNT_W'(1) : c;
    endfunction

    function automatic logic [TMR_W-1:0] gap_wait(input logic [GAP_W-1:0] g);
        return (g == '0) ? '0 : TMR_W'(g) - TMR_W'(1);
    endfunction

    dcs_addr_step #(.AW(ADDR_W), .WW(WRAP_W), .STEP(8)) u_step (
        .cur  (q.addr),
        .base (cur.addr),
        .inc  (cur.inc8),
        .wrap (cur.wrap),
        .nxt  (step_addr)
    );

    always_comb begin
        cur = desc[q.slot];
        nxt = desc[q.slot + SLOT_W'(1)];
        d = q;
        d.vld   = 1'b0;
        d.code  = '0;
        d.dir   = '0;
        d.oaddr = '0;
        d.obank = '0;
        d.orank = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.tmode  = go_timer;
                    d.last   = go_last;
                    d.done_n = 1'b0;
                    d.done_t = 1'b0;
                    if (go_loops == '0) begin
                        if (go_timer) d.done_t = 1'b1;
                        else          d.done_n = 1'b1;
                    end else begin
                        d.st    = ST_RUN;
                        d.slot  = '0;
                        d.loops = go_loops;
                        d.tmr   = '0;
                        d.left  = eff_count(desc[0].count);
                        d.addr  = desc[0].addr;
                        d.bank  = desc[0].bank;
                    end
                end
            end
            ST_RUN: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TMR_W'(1);
                end else begin
                    if (!q.tmode) begin
                        d.vld   = 1'b1;
                        d.code  = cur.code;
                        d.dir   = cur.dir;
                        d.orank = cur.rank;
                        d.oaddr = q.addr;
                        d.obank = q.bank;
                    end
                    if (q.left > CNT_W'(1)) begin
                        d.left = q.left - CNT_W'(1);
                        d.tmr  = gap_wait(cur.gap);
                        d.addr = step_addr;
                        if (cur.incbank) d.bank = q.bank + BANK_W'(1);
                    end else begin
                        d.tmr = TMR_W'(cur.post);
                        if (q.slot != q.last) begin
                            d.slot = q.slot + SLOT_W'(1);
                            d.left = eff_count(nxt.count);
                            d.addr = nxt.addr;
                            d.bank = nxt.bank;
                        end else if (q.loops > LOOP_W'(1)) begin
                            d.loops = q.loops - LOOP_W'(1);
                            d.slot  = '0;
                            d.left  = eff_count(desc[0].count);
                            d.addr  = desc[0].addr;
                            d.bank  = desc[0].bank;
                        end else begin
                            d.st = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (q.tmr != '0) begin
                    d.tmr = q.tmr - TMR_W'(1);
                end else begin
                    d.st = ST_IDLE;
                    if (q.tmode) d.done_t = 1'b1;
                    else         d.done_n = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid = q.vld;
    assign cmd_code  = q.code;
    assign cmd_addr  = q.oaddr;
    assign cmd_bank  = q.obank;
    assign cmd_rank  = q.orank;
    assign cmd_dir   = q.dir;
    assign busy      = (q.st != ST_IDLE);
    assign done_n    = q.done_n;
    assign done_t    = q.done_t;
    assign tmode     = q.tmode;
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [DIR_W-1:0]  cmd_dir
);
    desc_t       desc [NSLOT];
    logic        busy, done_n, done_t, tmode, go;
    logic [31:0] status_word;

    assign go = reg_we && (reg_addr == REG_START) && !busy;

    always_comb begin
        status_word            = '0;
        status_word[BUSY_BIT]  = busy;
        status_word[DONE_BIT]  = done_n;
        status_word[TDONE_BIT] = done_t;
    end

    dcs_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_we),
        .addr        (reg_addr),
        .wr_data     (reg_wdata),
        .lock        (busy),
        .status_word (status_word),
        .rd_data     (reg_rdata),
        .desc        (desc)
    );

    dcs_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_loops  (reg_wdata[LOOP_LSB +: LOOP_W]),
        .go_last   (reg_wdata[LAST_LSB +: SLOT_W]),
        .go_timer  (reg_wdata[TIMER_BIT]),
        .desc      (desc),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .cmd_bank  (cmd_bank),
        .cmd_rank  (cmd_rank),
        .cmd_dir   (cmd_dir),
        .busy      (busy),
        .done_n    (done_n),
        .done_t    (done_t),
        .tmode     (tmode)
    );
endmodule

// File: rtl/dram_cmd_seq_chk.sv
module dram_cmd_seq_chk
    import dcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [LOOP_W-1:0] start_loops,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [RANK_W-1:0] cmd_rank,
    input logic [DIR_W-1:0]  cmd_dir,
    input logic              busy,
    input logic              done_n,
    input logic              done_t,
    input logic              tmode
);
    // R5
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_code == '0 && cmd_addr == '0 && cmd_bank == '0
                        && cmd_rank == '0 && cmd_dir == '0));

    // R5
    pulse_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(busy));

    // R10
    silent_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !tmode);

    // R9
    busy_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(done_n || done_t));

    // R9
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_n, done_t}));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && reg_addr == REG_START && start_loops != '0) |=> busy);

    // R12
    relaunch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == REG_START) |=> $stable(tmode));
endmodule

bind dram_cmd_seq dram_cmd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .start_loops (reg_wdata[7:0]),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_addr    (cmd_addr),
    .cmd_bank    (cmd_bank),
    .cmd_rank    (cmd_rank),
    .cmd_dir     (cmd_dir),
    .busy        (busy),
    .done_n      (done_n),
    .done_t      (done_t),
    .tmode       (tmode)
);

// File: tb/dram_cmd_seq_test.sv
module dram_cmd_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CYCLE_LIMIT = 150000;
    localparam int LOGMAX = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = 5'd17;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [3:0]  cmd_code;
    logic [15:0] cmd_addr;
    logic [2:0]  cmd_bank;
    logic [1:0]  cmd_rank;
    logic [1:0]  cmd_dir;

    dram_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank),
        .cmd_rank(cmd_rank), .cmd_dir(cmd_dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slot configuration
    int c_code[4], c_cnt[4], c_gap[4], c_post[4], c_dir[4];
    int c_addr[4], c_bank[4], c_rank[4], c_inc8[4], c_incb[4], c_wrap[4];

    // expected and observed pulses
    int e_n, e_done;
    int e_t[LOGMAX], e_f[LOGMAX];
    int l_n;
    int l_t[LOGMAX], l_f[LOGMAX];
    bit log_en = 0;

    function automatic int pack(int code, int dir, int rank, int bank, int addr);
        return (code << 23) | (dir << 21) | (rank << 19) | (bank << 16) | addr;
    endfunction

    always @(negedge clk) begin
        if (log_en && cmd_valid && l_n < LOGMAX) begin
            l_t[l_n] = cyc;
            l_f[l_n] = pack(int'(cmd_code), int'(cmd_dir), int'(cmd_rank),
                            int'(cmd_bank), int'(cmd_addr));
            l_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(v);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 5'd17;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        reg_addr = 5'(a);
        #1 v = int'(reg_rdata);
        reg_addr = 5'd17;
    endtask

    task automatic program_slots();
        for (int s = 0; s < 4; s++) begin
            wr(4*s+0, c_code[s]);
            wr(4*s+1, c_cnt[s] | (c_dir[s] << 12) | (c_gap[s] << 16) | (c_post[s] << 24));
            wr(4*s+2, c_addr[s] | (c_bank[s] << 16) | (c_rank[s] << 20));
            wr(4*s+3, c_inc8[s] | (c_incb[s] << 1) | (c_wrap[s] << 4));
        end
    endtask

    function automatic int next_addr(int a, int start, int w);
        if (w >= 16) return (a + 8) & 16'hFFFF;
        if ((a % (1 << w)) + 8 >= (1 << w)) return start;
        return a + 8;
    endfunction

    task automatic build(input int last, input int loops);
        int t, a, b, n;
        e_n = 0;
        if (loops == 0) begin e_done = 1; return; end
        t = 2;
        for (int l = 0; l < loops; l++) begin
            for (int s = 0; s <= last; s++) begin
                a = c_addr[s]; b = c_bank[s];
                n = (c_cnt[s] == 0) ? 1 : c_cnt[s];
                for (int k = 0; k < n; k++) begin
                    e_t[e_n] = t;
                    e_f[e_n] = pack(c_code[s], c_dir[s], c_rank[s], b, a);
                    e_n++;
                    if (k < n-1) begin
                        t += (c_gap[s] == 0) ? 1 : c_gap[s];
                        if (c_inc8[s] != 0) a = next_addr(a, c_addr[s], c_wrap[s]);
                        if (c_incb[s] != 0) b = (b + 1) % 8;
                    end else begin
                        t += c_post[s] + 1;
                    end
                end
            end
        end
        e_done = t;
    endtask

    task automatic run(input int last, input int loops, input bit tm,
                       input bit disturb, input string tag);
        int sc, dc, guard, exp_n, want;
        build(last, loops);
        exp_n = tm ? 0 : e_n;
        l_n = 0;
        log_en = 1;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'd16;
        reg_wdata = 32'(loops | (last << 18) | (int'(tm) << 22));
        sc = cyc;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 5'd17;
        #1;
        // R13: launch clears done, busy is up
        if (loops > 0) chk((reg_rdata & 32'h51) == 32'h01, "R13 launch status",
                           int'(reg_rdata & 32'h51), 1);
        guard = 0;
        while ((reg_rdata & 32'h50) == 0 && guard < 20000) begin
            if (disturb && guard == 3) begin
                reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h0000_0007;
                @(negedge clk);
                reg_addr = 5'd16; reg_wdata = 32'h0040_0001;
                @(negedge clk);
                reg_we = 1'b0; reg_addr = 5'd17;
                guard += 2;
            end
            @(negedge clk);
            #1;
            guard++;
        end
        dc = cyc;
        log_en = 0;
        want = tm ? 32'h40 : 32'h10;
        chk(guard < 20000 && dc - sc == e_done, {tag, " R9 done cycle"}, dc - sc, e_done);
        chk(int'(reg_rdata & 32'h51) == want, {tag, " R9 R10 done bit"},
            int'(reg_rdata & 32'h51), want);
        chk(l_n == exp_n, {tag, " R3 pulse count"}, l_n, exp_n);
        for (int i = 0; i < l_n && i < exp_n; i++) begin
            chk(l_t[i] - sc == e_t[i], {tag, " R3 R4 pulse cycle"}, l_t[i] - sc, e_t[i]);
            chk(l_f[i] == e_f[i], {tag, " R5 R6 R7 pulse fields"}, l_f[i], e_f[i]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > CYCLE_LIMIT && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, CYCLE_LIMIT);
            finish_run();
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(reg_rdata == 32'h0, "R9 reset status", int'(reg_rdata), 0);
        chk(cmd_valid == 1'b0, "R5 reset bus", int'(cmd_valid), 0);

        // basic list: distinct slots, two passes (R1 R8)
        c_code = '{1, 2, 4, 3}; c_cnt = '{3, 1, 2, 4}; c_gap = '{2, 1, 3, 0};
        c_post = '{0, 4, 1, 7}; c_dir = '{0, 1, 0, 2}; c_addr = '{16, 5, 1024, 40};
        c_bank = '{1, 6, 0, 6}; c_rank = '{0, 1, 2, 3}; c_inc8 = '{1, 0, 0, 1};
        c_incb = '{0, 1, 0, 1}; c_wrap = '{5, 5, 5, 18};
        program_slots();
        rd(4*1+1, v);
        chk(v == (1 | (1 << 12) | (1 << 16) | (4 << 24)), "R1 readback", v,
            1 | (1 << 12) | (1 << 16) | (4 << 24));
        run(3, 2, 0, 0, "R1 R2 R8");

        // sweep of list length, gap and post-wait
        for (int last = 0; last < 4; last++) begin
            for (int gap = 0; gap < 4; gap++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    for (int s = 0; s < 4; s++) begin
                        c_code[s] = (s*3 + gap) % 8;
                        c_cnt[s]  = (s + gap + pi) % 4;
                        c_gap[s]  = gap;
                        c_post[s] = ((pi == 2) ? 3 : pi) + s;
                        c_dir[s]  = (s + pi) % 3;
                        c_addr[s] = s*64 + 8*pi;
                        c_bank[s] = (s + gap) % 8;
                        c_rank[s] = s;
                        c_inc8[s] = (s + gap) % 2;
                        c_incb[s] = (s + pi) % 2;
                        c_wrap[s] = 4 + (s % 3);
                    end
                    program_slots();
                    run(last, 1 + (gap + pi) % 2, 0, 0, "R2 R4 R6 R7 R8 sweep");
                end
            end
        end

        // long count and wrap position beyond the address width
        c_code = '{2, 3, 0, 0}; c_cnt = '{500, 3, 1, 1}; c_gap = '{1, 2, 1, 1};
        c_post = '{2, 0, 0, 0}; c_dir = '{1, 2, 0, 0}; c_addr = '{0, 16'hFFF0, 0, 0};
        c_bank = '{0, 7, 0, 0}; c_rank = '{1, 2, 0, 0}; c_inc8 = '{1, 1, 0, 0};
        c_incb = '{0, 1, 0, 0}; c_wrap = '{31, 31, 0, 0};
        program_slots();
        run(1, 1, 0, 0, "R3 R6 R7 long");

        // silent timing (R10), zero passes (R11), busy writes (R12)
        run(1, 1, 1, 0, "R10 silent");
        run(1, 0, 0, 0, "R11 zero pass");
        run(1, 0, 1, 0, "R11 R10 zero pass silent");
        run(1, 1, 0, 1, "R12 busy writes");
        rd(1, v);
        chk(v == (500 | (1 << 12) | (1 << 16) | (2 << 24)), "R12 slot word kept", v,
            500 | (1 << 12) | (1 << 16) | (2 << 24));

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule